// File: doc/BRIEF.md
# UART Interrupt Status and Routing

This block keeps the interrupt state of a serial port. It holds eleven latched event bits, a mask register of the same shape, and the masked view formed from the two. The event bits are set by single-cycle pulses from the receive path, the transmit path, the receive-timeout timer, the line-error detectors and the modem-status change detectors. The masked view drives six registered interrupt lines. One line is the combined request. The other five are grouped by cause: receive, transmit, receive timeout, modem status and line error.

Software reaches the block through a small register port. Address 0 is the mask, which can be read and written. Address 1 is the latched status and address 2 is the masked status; both are read-only. Address 3 is a clear register: each bit written as one clears the matching latched bit. The receive-level bit follows the occupancy of the receive FIFO. The FIFO reports its new count together with each push or pop pulse, and the block compares that count with a trigger count.

Top module: `uart_irq_router`

## Requirements
- R1: After reset the mask and the latched status are all zero, every register reads zero and all six interrupt lines are low.
- R2: Each event pulse sets one latched bit at a fixed position: modem_set[0] sets bit 0 (ring), modem_set[1] bit 1 (clear-to-send), modem_set[2] bit 2 (carrier detect), modem_set[3] bit 3 (data-set-ready), the receive-level event bit 4, tx_write bit 5, rx_timeout bit 6, err_set[0] bit 7 (framing), err_set[1] bit 8 (parity), err_set[2] bit 9 (break), err_set[3] bit 10 (overrun).
- R3: Reading address 2 returns the latched status ANDed with the mask.
- R4: A write to address 3 clears every latched bit whose position is written as one. Bits written as zero keep their value.
- R5: When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: Every pulse on tx_write sets the transmit bit (bit 5), whatever its previous state.
- R7: A push whose reported count equals rx_trig (nonzero) sets bit 4. A pop whose reported count equals rx_trig minus one clears bit 4. A push or pop reporting any other count leaves bit 4 unchanged.
- R8: irq_any is high exactly when some bit of the masked status is set.
- R9: irq_rx, irq_tx and irq_rt each follow masked bit 4, 5 and 6 respectively.
- R10: irq_ms is the OR of masked bits 0 to 3. irq_err is the OR of masked bits 7 to 10.
- R11: All six lines are registered. A change of the latched status or of the mask reaches the lines on the next clock edge after the register change.
- R12: Register bits 11 and up read as zero. Mask bits above bit 10 ignore writes, writes to addresses 1 and 2 have no effect, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 mask, 1 latched, 2 masked, 3 clear |
| reg_wen | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (combinational) |
| rx_push | input | 1 | Receive FIFO accepted a character |
| rx_pop | input | 1 | Receive FIFO gave up a character |
| rx_count | input | CNT_W | FIFO occupancy after the push or pop of this cycle |
| rx_trig | input | CNT_W | Receive trigger count |
| tx_write | input | 1 | A character was written for transmission |
| rx_timeout | input | 1 | Receive timeout event |
| err_set | input | 4 | Line errors: framing, parity, break, overrun (bit 0 to 3) |
| modem_set | input | 4 | Modem changes: ring, CTS, carrier, DSR (bit 0 to 3) |
| irq_any | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive-level interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rt | output | 1 | Receive-timeout interrupt |
| irq_ms | output | 1 | Modem-status interrupt |
| irq_err | output | 1 | Line-error interrupt |

## Verification
A wrong latched bit or mask bit shows up at once on the read port. Two cycles after the event that caused it, it also shows up on the interrupt lines, because the lines lag the registers by one edge. A bit that is lost or stuck under set/clear contention, or a receive-level bit that drops at the wrong count, leaves a latched value that differs from the one the stimulus implies. A wrong grouping of causes drives the wrong line even though the read views look correct, so the line checks are made against hand-computed masks for mixed cause patterns.

// File: rtl/uart_irq_pkg.sv
// Shared constants and types for the UART interrupt block.
// Assumes eleven interrupt causes and six output lines.
package uart_irq_pkg;

    localparam int NUM_SRC   = 11;
    localparam int NUM_LINES = 6;

    // Bit positions of the latched causes
    localparam int BIT_RI  = 0;
    localparam int BIT_CTS = 1;
    localparam int BIT_DCD = 2;
    localparam int BIT_DSR = 3;
    localparam int BIT_RX  = 4;
    localparam int BIT_TX  = 5;
    localparam int BIT_RT  = 6;
    localparam int BIT_FE  = 7;
    localparam int BIT_PE  = 8;
    localparam int BIT_BE  = 9;
    localparam int BIT_OE  = 10;

    typedef logic [NUM_SRC-1:0] irq_vec_t;

    localparam irq_vec_t GRP_MODEM = irq_vec_t'((1 << BIT_RI) | (1 << BIT_CTS) |
                                                (1 << BIT_DCD) | (1 << BIT_DSR));
    localparam irq_vec_t GRP_ERR   = irq_vec_t'((1 << BIT_FE) | (1 << BIT_PE) |
                                                (1 << BIT_BE) | (1 << BIT_OE));

    // Output line indices
    localparam int LINE_ANY = 0;
    localparam int LINE_RX  = 1;
    localparam int LINE_TX  = 2;
    localparam int LINE_RT  = 3;
    localparam int LINE_MS  = 4;
    localparam int LINE_ERR = 5;

    typedef enum logic [1:0] {
        REG_MASK   = 2'd0,
        REG_RAW    = 2'd1,
        REG_MASKED = 2'd2,
        REG_CLEAR  = 2'd3
    } reg_sel_e;

    // Which causes feed a given output line
    function automatic irq_vec_t line_group(input int idx);
        irq_vec_t g;
        case (idx)
            LINE_ANY: g = '1;
            LINE_RX:  g = irq_vec_t'(1 << BIT_RX);
            LINE_TX:  g = irq_vec_t'(1 << BIT_TX);
            LINE_RT:  g = irq_vec_t'(1 << BIT_RT);
            LINE_MS:  g = GRP_MODEM;
            default:  g = GRP_ERR;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/uart_irq_regif.sv
// Register port: holds the mask, produces the software clear vector and
// multiplexes read data. Assumes DATA_W >= NUM_SRC; upper bits read zero.
module uart_irq_regif
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    input  irq_vec_t          raw_q,
    output irq_vec_t          mask_q,
    output irq_vec_t          clr_sw,
    output logic [DATA_W-1:0] reg_rdata
);

    reg_sel_e sel;
    irq_vec_t wr_bits;
    logic     unused_wdata_hi;

    assign sel             = reg_sel_e'(reg_addr);
    assign wr_bits         = reg_wdata[NUM_SRC-1:0];
    assign unused_wdata_hi = |reg_wdata[DATA_W-1:NUM_SRC];

    // Mask register: written whole, only the implemented bits kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (reg_wen && sel == REG_MASK) begin
            mask_q <= wr_bits;
        end
    end

    // Write-one-to-clear strobe vector toward the status register
    always_comb begin
        clr_sw = '0;
        if (reg_wen && sel == REG_CLEAR) begin
            clr_sw = wr_bits;
        end
    end

    // Read data, zero extended
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            REG_MASK:   reg_rdata[NUM_SRC-1:0] = mask_q;
            REG_RAW:    reg_rdata[NUM_SRC-1:0] = raw_q;
            REG_MASKED: reg_rdata[NUM_SRC-1:0] = raw_q & mask_q;
            REG_CLEAR:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_irq_rxlevel.sv
// Receive-level event decode: turns FIFO push/pop pulses and the reported
// occupancy into set and clear requests for the receive bit.
// Assumes rx_count is the occupancy after this cycle's push or pop.
module uart_irq_rxlevel #(
    parameter int CNT_W = 5
) (
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    output logic             rx_set,
    output logic             rx_clr
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             trig_valid;
    logic [CNT_W-1:0] trig_m1;

    assign trig_valid = (rx_trig != '0);
    assign trig_m1    = rx_trig - ONE;

    // Raise on reaching the trigger, drop on falling just below it
    always_comb begin
        rx_set = rx_push && trig_valid && (rx_count == rx_trig);
        rx_clr = rx_pop  && trig_valid && (rx_count == trig_m1);
    end

endmodule

// File: rtl/uart_irq_status.sv
// Latched interrupt status. Set requests win over clear requests in
// the same cycle. Assumes all requests are single-cycle pulses.
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t set_vec,
    input  irq_vec_t clr_vec,
    output irq_vec_t raw_q
);

    // Update latched bits: clear first, then apply sets on top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_vec) | set_vec;
        end
    end

endmodule

// File: rtl/uart_irq_route.sv
// Output routing: masks the latched status and registers one OR per
// output line, using the group table in the package.
module uart_irq_route
    import uart_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  irq_vec_t             raw_q,
    input  irq_vec_t             mask_q,
    output logic [NUM_LINES-1:0] lines_q
);

    irq_vec_t             masked;
    logic [NUM_LINES-1:0] hit;

    assign masked = raw_q & mask_q;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam irq_vec_t GRP = line_group(i);
        assign hit[i] = |(masked & GRP);
    end

    // Register the lines so they change only on clock edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= '0;
        end else begin
            lines_q <= hit;
        end
    end

endmodule

// File: rtl/uart_irq_router.sv
// Top of the UART interrupt block: gathers the event pulses into the
// status set vector, merges software and receive-level clears, and
// routes the masked status to six registered lines.
// Assumes all event inputs are synchronous single-cycle pulses.
module uart_irq_router
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  rx_trig,
    input  logic              tx_write,
    input  logic              rx_timeout,
    input  logic [3:0]        err_set,
    input  logic [3:0]        modem_set,
    output logic              irq_any,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_rt,
    output logic              irq_ms,
    output logic              irq_err
);

    irq_vec_t             raw_q;
    irq_vec_t             mask_q;
    irq_vec_t             clr_sw;
    irq_vec_t             clr_all;
    irq_vec_t             set_vec;
    logic                 rx_set;
    logic                 rx_clr;
    logic [NUM_LINES-1:0] lines_q;

    uart_irq_regif #(.DATA_W(DATA_W)) regif_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .raw_q     (raw_q),
        .mask_q    (mask_q),
        .clr_sw    (clr_sw),
        .reg_rdata (reg_rdata)
    );

    uart_irq_rxlevel #(.CNT_W(CNT_W)) rxlevel_i (
        .rx_push  (rx_push),
        .rx_pop   (rx_pop),
        .rx_count (rx_count),
        .rx_trig  (rx_trig),
        .rx_set   (rx_set),
        .rx_clr   (rx_clr)
    );

    // Assemble set vector in status bit order (error group on top)
    assign set_vec = {err_set, rx_timeout, tx_write, rx_set, modem_set};

    // Software clears plus the receive-level drop
    assign clr_all = clr_sw | (irq_vec_t'(rx_clr) << BIT_RX);

    uart_irq_status status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_all),
        .raw_q   (raw_q)
    );

    uart_irq_route route_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .lines_q (lines_q)
    );

    assign irq_any = lines_q[LINE_ANY];
    assign irq_rx  = lines_q[LINE_RX];
    assign irq_tx  = lines_q[LINE_TX];
    assign irq_rt  = lines_q[LINE_RT];
    assign irq_ms  = lines_q[LINE_MS];
    assign irq_err = lines_q[LINE_ERR];

endmodule

// File: rtl/uart_irq_router_chk.sv
// Checker for uart_irq_router, attached by bind. Observes the status and
// mask registers, the set vector and the output lines.
module uart_irq_router_chk
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_addr,
    input logic              reg_wen,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              rx_push,
    input logic              rx_pop,
    input logic [CNT_W-1:0]  rx_count,
    input logic [CNT_W-1:0]  rx_trig,
    input irq_vec_t          raw_q,
    input irq_vec_t          mask_q,
    input irq_vec_t          set_vec,
    input logic              irq_any,
    input logic              irq_ms,
    input logic              irq_err
);

    // R2 / R5: every requested set is present after the edge
    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

    // R4: a clear with no competing set removes the written bits
    p_clear_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 2'd3 && set_vec == '0)
        |=> ((raw_q & $past(reg_wdata[NUM_SRC-1:0])) == '0));

    // R4: with no write, no set and no pop, the status holds
    p_status_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wen && set_vec == '0 && !rx_pop) |=> $stable(raw_q));

    // R7: a pop to one below the trigger drops the receive bit
    p_rx_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && rx_trig != '0 &&
         {1'b0, rx_count} == {1'b0, rx_trig} - 1'b1)
        |=> !raw_q[BIT_RX]);

    // R8 / R11: combined line follows the masked status one edge later
    p_any_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_any == |($past(raw_q) & $past(mask_q))));

    // R10: error group line
    p_err_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_err == |($past(raw_q & mask_q) & GRP_ERR)));

    // R10: modem group line
    p_ms_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_ms == |($past(raw_q & mask_q) & GRP_MODEM)));

    // R12: mask never holds bits a write tried to put above the top cause
    p_mask_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 2'd0)
        |=> (mask_q == $past(reg_wdata[NUM_SRC-1:0])));

endmodule

bind uart_irq_router uart_irq_router_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .rx_push   (rx_push),
    .rx_pop    (rx_pop),
    .rx_count  (rx_count),
    .rx_trig   (rx_trig),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .set_vec   (set_vec),
    .irq_any   (irq_any),
    .irq_ms    (irq_ms),
    .irq_err   (irq_err)
);

// File: tb/uart_irq_router_tb_top.sv
// Bench for uart_irq_router: a vector table walked by one loop, then
// directed tests for reset, bit positions, clears and timing.
module uart_irq_router_tb_top;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 5;
    localparam int NVEC   = 9;

    // {set pattern[10:0], mask[10:0], expected lines {any,rx,tx,rt,ms,err}}
    localparam logic [27:0] VEC [NVEC] = '{
        {11'h001, 11'h001, 6'b100010},
        {11'h010, 11'h7FF, 6'b110000},
        {11'h020, 11'h000, 6'b000000},
        {11'h040, 11'h040, 6'b100100},
        {11'h480, 11'h400, 6'b100001},
        {11'h00E, 11'h7F1, 6'b000000},
        {11'h7FF, 11'h200, 6'b100001},
        {11'h300, 11'h0FF, 6'b000000},
        {11'h020, 11'h020, 6'b101000}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        reg_addr;
    logic              reg_wen;
    logic [DATA_W-1:0] reg_wdata;
    logic [DATA_W-1:0] reg_rdata;
    logic              rx_push, rx_pop;
    logic [CNT_W-1:0]  rx_count, rx_trig;
    logic              tx_write, rx_timeout;
    logic [3:0]        err_set, modem_set;
    logic              irq_any, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_irq_router #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .reg_addr (reg_addr), .reg_wen (reg_wen),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .rx_push (rx_push), .rx_pop (rx_pop),
        .rx_count (rx_count), .rx_trig (rx_trig),
        .tx_write (tx_write), .rx_timeout (rx_timeout),
        .err_set (err_set), .modem_set (modem_set),
        .irq_any (irq_any), .irq_rx (irq_rx), .irq_tx (irq_tx),
        .irq_rt (irq_rt), .irq_ms (irq_ms), .irq_err (irq_err)
    );

    function automatic logic [5:0] lines();
        return {irq_any, irq_rx, irq_tx, irq_rt, irq_ms, irq_err};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read without consuming an edge; call just after a falling edge
    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wen   = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic pulse(input logic [10:0] s);
        @(negedge clk);
        modem_set  = s[3:0];
        rx_push    = s[4];
        rx_count   = s[4] ? rx_trig : '0;
        tx_write   = s[5];
        rx_timeout = s[6];
        err_set    = s[10:7];
        @(negedge clk);
        modem_set  = '0;
        rx_push    = 1'b0;
        tx_write   = 1'b0;
        rx_timeout = 1'b0;
        err_set    = '0;
    endtask

    task automatic rx_evt(input logic push, input logic pop, input logic [CNT_W-1:0] cnt);
        @(negedge clk);
        rx_push  = push;
        rx_pop   = pop;
        rx_count = cnt;
        @(negedge clk);
        rx_push  = 1'b0;
        rx_pop   = 1'b0;
    endtask

    task automatic clear_all();
        wr(2'd3, 32'h7FF);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; reg_addr = '0; reg_wen = 1'b0; reg_wdata = '0;
        rx_push = 1'b0; rx_pop = 1'b0; rx_count = '0; rx_trig = 5'd4;
        tx_write = 1'b0; rx_timeout = 1'b0; err_set = '0; modem_set = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd1, d); check("R1 raw after reset", d, 0);
        rd(2'd0, d); check("R1 mask after reset", d, 0);
        check("R1 lines after reset", lines(), 0);

        // Table walk: R2 latched value, R3 masked view, R8/R9/R10 lines
        for (int i = 0; i < NVEC; i++) begin
            logic [10:0] s, m;
            logic [5:0]  e;
            {s, m, e} = VEC[i];
            clear_all();
            wr(2'd0, {21'd0, m});
            pulse(s);
            rd(2'd1, d); check("R2 table raw", d, {21'd0, s});
            rd(2'd2, d); check("R3 table masked", d, {21'd0, s & m});
            @(negedge clk);
            check("R8 R9 R10 table lines", lines(), e);
        end

        // R2: each input lands at its own position
        wr(2'd0, 32'h0);
        for (int b = 0; b < 11; b++) begin
            clear_all();
            pulse(11'h1 << b);
            rd(2'd1, d); check("R2 single bit", d, 32'h1 << b);
        end

        // R4: partial write-one-to-clear
        clear_all();
        pulse(11'h7FF);
        wr(2'd3, 32'h0A5);
        rd(2'd1, d); check("R4 partial clear", d, 32'h75A);

        // R5: set and clear of the transmit bit in the same cycle
        clear_all();
        @(negedge clk);
        reg_addr = 2'd3; reg_wen = 1'b1; reg_wdata = 32'h060; tx_write = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0; tx_write = 1'b0;
        rd(2'd1, d); check("R5 set wins", d, 32'h020);

        // R6: repeated transmit writes keep the bit set
        clear_all();
        pulse(11'h020);
        pulse(11'h020);
        rd(2'd1, d); check("R6 tx write sets bit", d, 32'h020);

        // R7: receive level against trigger 4
        clear_all();
        rx_evt(1'b1, 1'b0, 5'd3);
        rd(2'd1, d); check("R7 below trigger no set", d, 0);
        rx_evt(1'b1, 1'b0, 5'd4);
        rd(2'd1, d); check("R7 reach trigger sets", d, 32'h010);
        rx_evt(1'b0, 1'b1, 5'd4);
        rd(2'd1, d); check("R7 pop above keeps", d, 32'h010);
        rx_evt(1'b0, 1'b1, 5'd3);
        rd(2'd1, d); check("R7 pop to trig-1 clears", d, 0);

        // R11: one-edge lag of the lines after status and mask changes
        clear_all();
        wr(2'd0, 32'h040);
        pulse(11'h040);
        check("R11 line not yet up", {31'd0, irq_rt}, 0);
        @(negedge clk);
        check("R11 line up next edge", {31'd0, irq_rt}, 1);
        wr(2'd0, 32'h0);
        check("R11 line still up after mask write", {31'd0, irq_rt}, 1);
        @(negedge clk);
        check("R11 line down next edge", {31'd0, irq_rt}, 0);

        // R12: upper bits and read-only addresses
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R12 mask upper bits", d, 32'h7FF);
        clear_all();
        wr(2'd1, 32'h7FF);
        rd(2'd1, d); check("R12 raw write ignored", d, 0);
        wr(2'd2, 32'h7FF);
        rd(2'd2, d); check("R12 masked write ignored", d, 0);
        rd(2'd3, d); check("R12 clear reads zero", d, 0);

        // R1: reset in mid-run
        pulse(11'h7FF);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd1, d); check("R1 raw after mid reset", d, 0);
        rd(2'd0, d); check("R1 mask after mid reset", d, 0);
        check("R1 lines after mid reset", lines(), 0);

        finish_run();
    end

endmodule